// File: doc/BRIEF.md
# Capacitor voltage sort-and-select balancer

This block serves one converter arm of N series submodules. It takes every submodule's measured capacitor voltage, ranks them, and returns an N-bit mask of the submodules to insert. The number of submodules to insert is requested from outside. The polarity of the arm current picks the ranking direction. While the current charges the capacitors, the least-charged submodules are inserted. While it discharges them, the most-charged ones are inserted. Over many sort periods this keeps the capacitor voltages of the arm close together.

An optional predictive mode first moves each voltage forward by the charge the arm current will deliver in one sort period. That charge is the arm current times a signed fixed-point gain, which stands for the sort period divided by the capacitance. The block then ranks by distance from a reference voltage. When even the worst predicted distance lies outside a tolerance band, the block falls back to plain ranking.

A sort starts on a trigger, either an external pulse (for example, aligned to the PWM period) or an internal free-running period timer. The block copies its inputs at the trigger. It then ranks them with an odd-even transposition network, one pass per clock, and replaces the mask in one step when the ranking is done.

Top module: `cap_sort_balancer`

## Requirements
- R1: Capacitor voltage of submodule i is `vcap_i[i*VW +: VW]` (unsigned), and `mask_o[i]` set means insert submodule i. With `iarm_i >= 0` and conventional ranking, the requested number of submodules with the lowest voltages are inserted.
- R2: With `iarm_i < 0` and conventional ranking, the requested number of submodules with the highest voltages are inserted.
- R3: Equal ranking keys are ordered by ascending submodule index, so the lower index is inserted first.
- R4: The requested count `count_i` is saturated to N, and after every sort the number of set bits in `mask_o` equals the saturated count.
- R5: With `trig_ext_i` = 1 a sort starts only when `start_i` is high in an idle cycle. With `trig_ext_i` = 0 a sort starts every `period_i` cycles from an internal timer (a value of 0 acts as 1), and `start_i` has no effect.
- R6: The inputs are captured at the trigger edge. `busy_o` is high for N ranking cycles plus one commit cycle, and `mask_o` keeps its previous value until the commit edge. Triggers while busy are ignored.
- R7: In predictive mode each predicted voltage is v + floor(iarm_i * gain_i / 2^GF), where `gain_i` is signed with GF fraction bits and the division rounds toward minus infinity.
- R8: When predictive ranking is in force, the requested number of submodules with the smallest |predicted voltage - `vref_i`| are inserted, whatever the current polarity.
- R9: Predictive ranking is in force only when `pred_en_i` = 1 and the largest predicted deviation is at most `tol_i`. When the largest deviation exceeds `tol_i`, conventional ranking (R1/R2) is used.
- R10: During reset and directly after it, `mask_o` is all zeros and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_ext_i | input | 1 | 1: external start pulse, 0: internal period timer |
| start_i | input | 1 | External sort request |
| period_i | input | TW | Internal sort period in clock cycles |
| vcap_i | input | N*VW | Packed capacitor voltages, submodule 0 in the low bits |
| iarm_i | input | IW | Signed arm current |
| gain_i | input | GW | Signed period-over-capacitance gain, GF fraction bits |
| pred_en_i | input | 1 | Enable predictive ranking |
| vref_i | input | VW | Reference voltage for predictive ranking |
| tol_i | input | VW | Tolerance band on predicted deviation |
| count_i | input | clog2(N+1)+1 | Requested number of inserted submodules |
| mask_o | output | N | Insert mask |
| busy_o | output | 1 | Sort in progress |

## Verification
The bench builds the block with N = 6, VW = 10, IW = 8, GW = 8 and GF = 4. Six submodules are enough to write every expected mask by hand. They still give three even and three odd transposition phases, room for ties, and count requests above N that the 4-bit count port can carry. Four fraction bits let a gain of 1.5 produce a half-unit step, so floor rounding of a negative charge step changes which submodule wins. A 16-bit timer with a period of 20 keeps the internal-trigger case inside a short window.

// File: rtl/cap_sort_pkg.sv
package cap_sort_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SORT   = 2'd1,
    ST_COMMIT = 2'd2
  } sort_state_e;

  // Width of a ranking key: holds a zero-extended voltage or an absolute
  // predicted deviation without overflow.
  function automatic int key_width(int vw, int iw, int gw, int gf);
    int step_w;
    int pw;
    step_w = iw + gw - gf;
    pw     = ((step_w > vw + 1) ? step_w : vw + 1) + 1;
    return pw + 1;
  endfunction

endpackage

// File: rtl/cap_sort_trigger.sv
module cap_sort_trigger #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_sel_i,
  input  logic          start_i,
  input  logic [TW-1:0] period_i,
  output logic          fire_o
);

  logic [TW-1:0] tmr_q, tmr_d, limit;
  logic          tmr_hit;

  always_comb begin
    limit   = (period_i == '0) ? '0 : period_i - 1'b1;
    tmr_hit = !ext_sel_i && (tmr_q >= limit);
    if (ext_sel_i || tmr_hit) tmr_d = '0;
    else                      tmr_d = tmr_q + 1'b1;
    fire_o  = ext_sel_i ? start_i : tmr_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

endmodule

// File: rtl/cap_sort_keygen.sv
module cap_sort_keygen #(
  parameter int N  = 6,
  parameter int VW = 10,
  parameter int IW = 8,
  parameter int GW = 8,
  parameter int GF = 4,
  parameter int KW = 14
) (
  input  logic [N*VW-1:0]        vcap_i,
  input  logic signed [IW-1:0]   iarm_i,
  input  logic signed [GW-1:0]   gain_i,
  input  logic                   pred_en_i,
  input  logic [VW-1:0]          vref_i,
  input  logic [VW-1:0]          tol_i,
  output logic [N-1:0][KW-1:0]   key_o,
  output logic                   pred_sel_o
);

  localparam int PRW = IW + GW;

  logic signed [PRW-1:0] prod, step;
  logic signed [KW-1:0]  step_x, vref_x;
  logic [N-1:0][KW-1:0]  dev, conv;
  logic [KW-1:0]         dev_max;

  assign prod   = iarm_i * gain_i;
  assign step   = prod >>> GF;          // floor division by 2^GF
  assign step_x = KW'(step);
  assign vref_x = signed'(KW'(vref_i));

  for (genvar i = 0; i < N; i++) begin : g_key
    logic [VW-1:0]        v;
    logic signed [KW-1:0] vx, diff;
    assign v       = vcap_i[i*VW +: VW];
    assign vx      = signed'(KW'(v));
    assign diff    = vx + step_x - vref_x;
    assign dev[i]  = diff[KW-1] ? $unsigned(-diff) : $unsigned(diff);
    // Discharging ranks by inverted voltage so ascending keys give highest first.
    assign conv[i] = iarm_i[IW-1] ? KW'(~v) : KW'(v);
    assign key_o[i] = pred_sel_o ? dev[i] : conv[i];
  end

  always_comb begin
    dev_max = '0;
    for (int i = 0; i < N; i++) begin
      if (dev[i] > dev_max) dev_max = dev[i];
    end
  end

  assign pred_sel_o = pred_en_i && (dev_max <= KW'(tol_i));

endmodule

// File: rtl/cap_sort_pass.sv
module cap_sort_pass #(
  parameter int N  = 6,
  parameter int KW = 14,
  parameter int XW = 3
) (
  input  logic                 odd_i,
  input  logic [N-1:0][KW-1:0] key_i,
  input  logic [N-1:0][XW-1:0] idx_i,
  output logic [N-1:0][KW-1:0] key_o,
  output logic [N-1:0][XW-1:0] idx_o
);

  logic [N-1:0] swap;

  for (genvar i = 0; i < N - 1; i++) begin : g_cmp
    localparam logic PAR = 1'((i % 2) == 1);
    assign swap[i] = (odd_i == PAR) &&
                     ((key_i[i] > key_i[i+1]) ||
                      ((key_i[i] == key_i[i+1]) && (idx_i[i] > idx_i[i+1])));
  end
  assign swap[N-1] = 1'b0;

  for (genvar j = 0; j < N; j++) begin : g_mux
    if (j == 0) begin : g_first
      assign key_o[j] = swap[0] ? key_i[1] : key_i[0];
      assign idx_o[j] = swap[0] ? idx_i[1] : idx_i[0];
    end else if (j == N - 1) begin : g_last
      assign key_o[j] = swap[j-1] ? key_i[j-1] : key_i[j];
      assign idx_o[j] = swap[j-1] ? idx_i[j-1] : idx_i[j];
    end else begin : g_mid
      assign key_o[j] = swap[j-1] ? key_i[j-1] : (swap[j] ? key_i[j+1] : key_i[j]);
      assign idx_o[j] = swap[j-1] ? idx_i[j-1] : (swap[j] ? idx_i[j+1] : idx_i[j]);
    end
  end

endmodule

// File: rtl/cap_sort_balancer.sv
module cap_sort_balancer
  import cap_sort_pkg::*;
#(
  parameter int N  = 6,
  parameter int VW = 10,
  parameter int IW = 8,
  parameter int GW = 8,
  parameter int GF = 4,
  parameter int TW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trig_ext_i,
  input  logic                    start_i,
  input  logic [TW-1:0]           period_i,
  input  logic [N*VW-1:0]         vcap_i,
  input  logic signed [IW-1:0]    iarm_i,
  input  logic signed [GW-1:0]    gain_i,
  input  logic                    pred_en_i,
  input  logic [VW-1:0]           vref_i,
  input  logic [VW-1:0]           tol_i,
  input  logic [$clog2(N+1):0]    count_i,
  output logic [N-1:0]            mask_o,
  output logic                    busy_o
);

  localparam int KW = key_width(VW, IW, GW, GF);
  localparam int XW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(N + 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic                 fire;
  logic                 pred_sel;
  logic [N-1:0][KW-1:0] key_new, pass_key;
  logic [N-1:0][XW-1:0] pass_idx;

  sort_state_e          state_q, state_d;
  logic [XW-1:0]        pass_q, pass_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [N-1:0][KW-1:0] key_q, key_d;
  logic [N-1:0][XW-1:0] idx_q, idx_d;
  logic [N-1:0]         mask_q, mask_d;
  logic                 arr_en, mask_en;

  cap_sort_trigger #(.TW(TW)) u_trig (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ext_sel_i (trig_ext_i),
    .start_i   (start_i),
    .period_i  (period_i),
    .fire_o    (fire)
  );

  cap_sort_keygen #(
    .N(N), .VW(VW), .IW(IW), .GW(GW), .GF(GF), .KW(KW)
  ) u_key (
    .vcap_i     (vcap_i),
    .iarm_i     (iarm_i),
    .gain_i     (gain_i),
    .pred_en_i  (pred_en_i),
    .vref_i     (vref_i),
    .tol_i      (tol_i),
    .key_o      (key_new),
    .pred_sel_o (pred_sel)
  );

  cap_sort_pass #(.N(N), .KW(KW), .XW(XW)) u_pass (
    .odd_i (pass_q[0]),
    .key_i (key_q),
    .idx_i (idx_q),
    .key_o (pass_key),
    .idx_o (pass_idx)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    pass_d  = pass_q;
    cnt_d   = cnt_q;
    key_d   = key_q;
    idx_d   = idx_q;
    mask_d  = mask_q;
    arr_en  = 1'b0;
    mask_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (fire) begin
          arr_en = 1'b1;
          key_d  = key_new;
          for (int i = 0; i < N; i++) idx_d[i] = XW'(i);
          cnt_d   = (int'(count_i) > N) ? CW'(N) : CW'(count_i);
          pass_d  = '0;
          state_d = ST_SORT;
        end
      end
      ST_SORT: begin
        arr_en = 1'b1;
        key_d  = pass_key;
        idx_d  = pass_idx;
        pass_d = pass_q + 1'b1;
        if (pass_q == XW'(N - 1)) state_d = ST_COMMIT;
      end
      ST_COMMIT: begin
        mask_en = 1'b1;
        mask_d  = '0;
        for (int p = 0; p < N; p++) begin
          if (p < int'(cnt_q)) mask_d[idx_q[p]] = 1'b1;
        end
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      pass_q  <= '0;
      cnt_q   <= '0;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
      cnt_q   <= cnt_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      key_q <= '0;
      idx_q <= '0;
    end else if (arr_en) begin
      key_q <= key_d;
      idx_q <= idx_d;
    end
  end

  assign mask_o = mask_q;
  assign busy_o = (state_q != ST_IDLE);

  // Checks
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q != ST_COMMIT) |=> $stable(mask_q)); // R6

  AST_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_COMMIT) |=> ($countones(mask_q) == int'(cnt_q))); // R4

  AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (int'(cnt_q) <= N)); // R4

  AST_PASS_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_SORT) |-> (int'(pass_q) < N)); // R6

  AST_PRED_GATE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pred_sel |-> pred_en_i); // R9

  for (genvar i = 0; i < N - 1; i++) begin : g_order_chk
    AST_SORT_ORDER: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (state_q == ST_COMMIT) |->
        ((key_q[i] < key_q[i+1]) ||
         ((key_q[i] == key_q[i+1]) && (idx_q[i] < idx_q[i+1])))); // R3
  end

endmodule

// File: tb/sim_cap_sort_balancer.sv
module sim_cap_sort_balancer;

  localparam int N  = 6;
  localparam int VW = 10;
  localparam int NV = 16;

  typedef struct packed {
    logic [N*VW-1:0]    v;
    logic signed [7:0]  ia;
    logic [3:0]         cnt;
    logic               pe;
    logic signed [7:0]  g;
    logic [9:0]         vr;
    logic [9:0]         tl;
    logic [5:0]         ex;
    logic [7:0]         rq;
  } vec_t;

  function automatic logic [N*VW-1:0] mkv(int a0, int a1, int a2, int a3, int a4, int a5);
    return {10'(a5), 10'(a4), 10'(a3), 10'(a2), 10'(a1), 10'(a0)};
  endfunction

  localparam vec_t VEC [NV] = '{
    '{mkv(104,105,101,103,102,96),  8'sd5, 4'd2,  1'b0, 8'sd0,  10'd0,   10'd0,  6'h24, 8'd1}, // R1
    '{mkv(104,105,101,103,102,96), -8'sd5, 4'd2,  1'b0, 8'sd0,  10'd0,   10'd0,  6'h03, 8'd2}, // R2
    '{mkv(104,105,101,103,102,96),  8'sd0, 4'd3,  1'b0, 8'sd0,  10'd0,   10'd0,  6'h34, 8'd1}, // R1 zero current
    '{mkv(104,105,101,103,102,96), -8'sd5, 4'd4,  1'b0, 8'sd0,  10'd0,   10'd0,  6'h1B, 8'd2}, // R2
    '{mkv(50,50,50,50,50,50),       8'sd1, 4'd2,  1'b0, 8'sd0,  10'd0,   10'd0,  6'h03, 8'd3}, // R3
    '{mkv(50,50,50,50,50,50),      -8'sd1, 4'd3,  1'b0, 8'sd0,  10'd0,   10'd0,  6'h07, 8'd3}, // R3
    '{mkv(104,105,101,103,102,96),  8'sd5, 4'd0,  1'b0, 8'sd0,  10'd0,   10'd0,  6'h00, 8'd4}, // R4
    '{mkv(104,105,101,103,102,96),  8'sd5, 4'd9,  1'b0, 8'sd0,  10'd0,   10'd0,  6'h3F, 8'd4}, // R4
    '{mkv(104,105,101,103,102,96), -8'sd5, 4'd15, 1'b0, 8'sd0,  10'd0,   10'd0,  6'h3F, 8'd4}, // R4
    '{mkv(90,100,110,95,105,99),    8'sd4, 4'd2,  1'b1, 8'sd16, 10'd100, 10'd20, 6'h28, 8'd8}, // R8
    '{mkv(90,100,110,95,105,99),    8'sd4, 4'd2,  1'b1, 8'sd16, 10'd100, 10'd14, 6'h28, 8'd9}, // R9 equal
    '{mkv(90,100,110,95,105,99),    8'sd4, 4'd2,  1'b1, 8'sd16, 10'd100, 10'd13, 6'h09, 8'd9}, // R9 exceed
    '{mkv(90,100,110,95,105,99),   -8'sd4, 4'd2,  1'b1, 8'sd16, 10'd100, 10'd20, 6'h12, 8'd8}, // R8
    '{mkv(90,100,110,95,105,99),   -8'sd4, 4'd2,  1'b0, 8'sd16, 10'd100, 10'd20, 6'h14, 8'd2}, // R2
    '{mkv(90,100,110,95,105,99),   -8'sd4, 4'd2,  1'b1, 8'sd16, 10'd100, 10'd13, 6'h14, 8'd9}, // R9
    '{mkv(105,96,104,100,100,100), -8'sd3, 4'd1,  1'b1, 8'sd24, 10'd100, 10'd20, 6'h01, 8'd7}  // R7 floor
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              trig_ext, start;
  logic [15:0]       period;
  logic [N*VW-1:0]   vcap;
  logic signed [7:0] iarm, gain;
  logic              pred_en;
  logic [VW-1:0]     vref, tol;
  logic [3:0]        count;
  logic [N-1:0]      mask;
  logic              busy;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cap_sort_balancer u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_ext_i (trig_ext),
    .start_i    (start),
    .period_i   (period),
    .vcap_i     (vcap),
    .iarm_i     (iarm),
    .gain_i     (gain),
    .pred_en_i  (pred_en),
    .vref_i     (vref),
    .tol_i      (tol),
    .count_i    (count),
    .mask_o     (mask),
    .busy_o     (busy)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(vec_t t);
    vcap    = t.v;
    iarm    = t.ia;
    count   = t.cnt;
    pred_en = t.pe;
    gain    = t.g;
    vref    = t.vr;
    tol     = t.tl;
  endtask

  // Pulse start, then wait until one negedge past the commit edge.
  task automatic run_sort();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (N + 1) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; trig_ext = 1'b1; start = 1'b0; period = 16'd0;
    apply(VEC[0]);
    repeat (3) @(negedge clk);
    chk("R10 mask in reset", 32'(mask), 32'h0);
    chk("R10 busy in reset", 32'(busy), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 mask after reset", 32'(mask), 32'h0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk) apply(VEC[k]);
      run_sort();
      chk($sformatf("R%0d vector %0d", VEC[k].rq, k), 32'(mask), 32'(VEC[k].ex));
    end

    // R6: busy window, mask held, snapshot, trigger while busy ignored
    @(negedge clk) apply(VEC[0]); start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R6 busy after trigger", 32'(busy), 32'h1);
    chk("R6 mask held at start", 32'(mask), 32'h01);
    @(negedge clk) apply(VEC[1]); start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (N - 2) @(negedge clk);
    chk("R6 busy in commit cycle", 32'(busy), 32'h1);
    chk("R6 mask held before commit", 32'(mask), 32'h01);
    @(negedge clk);
    chk("R6 busy cleared", 32'(busy), 32'h0);
    chk("R6 snapshot result", 32'(mask), 32'h24);

    // R5: no trigger, no change
    repeat (20) @(negedge clk);
    chk("R5 no trigger keeps mask", 32'(mask), 32'h24);

    // R5: internal timer, start ignored
    trig_ext = 1'b0; period = 16'd20;
    repeat (10) @(negedge clk);
    chk("R5 timer not yet fired", 32'(mask), 32'h24);
    repeat (30) @(negedge clk);
    chk("R5 timer driven sort", 32'(mask), 32'h03);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule